// File: doc/BRIEF.md
# Master-Clock Ratio Detector With Mute

This block measures how many master-clock cycles fit in one period of the sample clock (the left/right word clock), and classifies that count against six supported oversampling ratios: 128, 192, 256, 384, 512 and 768 master clocks per sample. A count is accepted as a ratio when it lies within eight master clocks of that ratio's nominal value. The result drives a downstream converter. It receives a 3-bit ratio code and a lock flag. A mute request is raised whenever no supported ratio can be trusted.

The word clock is brought into the master-clock domain through a two-flop synchroniser. Each of its rising edges closes one measurement window and opens the next. A ratio is committed only after two consecutive windows agree. One window that matches nothing, or that matches a different ratio, drops lock at once and requests mute. The period counter saturates, so a word clock that stops is reported as an error and does not wrap into a false match.

An enable input gates the whole detector. While enable is low the block sits idle and muted. Detection begins only after enable goes from low to high. An enable that is already high when reset is released does not start it.

Top module: `mclk_ratio_detect`

## Requirements
- R1: The ratio code is 0, 1, 2, 3, 4 or 5 for 128, 192, 256, 384, 512 and 768 master clocks per sample period, and 7 when no ratio is committed.
- R2: A measured period within 8 master clocks above or below a nominal ratio is accepted as that ratio. Examples: 520, 504, 120 and 776 are accepted.
- R3: A measured period more than 8 clocks away from every nominal ratio (for example 521, 300 or 320) clears lock_o, sets mute_o and sets ratio_o to 7 on that measurement.
- R4: lock_o rises, mute_o falls and ratio_o takes the code only when two consecutive measured periods map to the same code. A valid measurement that maps to a different code than the previous one clears lock and mutes.
- R5: A period is the number of master-clock rising edges between two synchronised word-clock rising edges. The first word-clock rise after enable only opens a window. The outputs update on the third master-clock rising edge after the first edge that samples the word clock high.
- R6: Period-to-period jitter and phase changes of the word clock that keep every window within tolerance never clear lock or raise mute.
- R7: The period counter saturates at 2**CNT_W-1. A word clock that stops for that many master clocks clears lock and asserts mute.
- R8: While en_i is low, from the next master-clock edge on, lock_o is 0, mute_o is 1 and ratio_o is 7, whatever the word clock does.
- R9: Detection starts only after a low-to-high transition of en_i. An en_i that is already high out of reset leaves the block idle.
- R10: After reset, lock_o is 0, mute_o is 1 and ratio_o is 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock; every register runs on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Detector enable; a low-to-high transition starts detection |
| lrclk_i | input | 1 | Sample-rate word clock, asynchronous in phase to clk_i |
| ratio_o | output | 3 | Committed ratio code (0..5), 7 when none |
| lock_o | output | 1 | High while a ratio is committed |
| mute_o | output | 1 | Mute / shutdown request to the converter |

## Verification
A word-clock rise driven before master-clock edge k is seen by the synchroniser at edges k and k+1. The measurement register loads at edge k+2, and the ratio, lock and mute registers load at edge k+3. One directed task samples on the falling edges right after k+2 and k+3 to pin that latency exactly. Every other check is taken on a falling edge after a whole number of word-clock periods, which is at least 120 cycles after the last measurement and so well past the three-edge latency. The disable check waits two falling edges after en_i drops. The stopped-clock check waits 1100 cycles, which covers the 1023-edge saturation plus the pipeline.

// File: rtl/mrd_pkg.sv
package mrd_pkg;
  localparam int NUM_RATIO = 6;

  typedef logic [2:0] ratio_code_t;
  localparam ratio_code_t RATIO_NONE = 3'd7;

  // Nominal master clocks per sample for each code, ascending
  function automatic int nominal_ratio(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/mrd_lrclk_sync.sv
module mrd_lrclk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrclk_i,
  output logic rise_o
);
  localparam int W = STAGES + 1;

  logic [W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '0;
    else         stg_q <= {stg_q[W-2:0], lrclk_i};
  end

  assign rise_o = stg_q[STAGES-1] & ~stg_q[STAGES];
endmodule

// File: rtl/mrd_enable_ctl.sv
module mrd_enable_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic active_o
);
  logic en_q, armed_q;

  // en_q resets high so an enable already high out of reset is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b1;
      armed_q <= 1'b0;
    end else begin
      en_q <= en_i;
      if (!en_i)      armed_q <= 1'b0;
      else if (!en_q) armed_q <= 1'b1;
    end
  end

  assign active_o = armed_q & en_i;
endmodule

// File: rtl/mrd_period_counter.sv
module mrd_period_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] meas_o,
  output logic             meas_valid_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             open_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q        <= '0;
      open_q       <= 1'b0;
      meas_o       <= '0;
      meas_valid_o <= 1'b0;
    end else if (!active_i) begin
      cnt_q        <= '0;
      open_q       <= 1'b0;
      meas_o       <= '0;
      meas_valid_o <= 1'b0;
    end else begin
      meas_valid_o <= 1'b0;
      if (rise_i) begin
        if (open_q) begin
          meas_o       <= cnt_q;
          meas_valid_o <= 1'b1;
        end
        open_q <= 1'b1;
        cnt_q  <= CNT_ONE;
      end else if (open_q) begin
        if (cnt_q == CNT_MAX) begin
          // stalled word clock: keep reporting an impossible period
          meas_o       <= CNT_MAX;
          meas_valid_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CNT_ONE;
        end
      end
    end
  end
endmodule

// File: rtl/mrd_ratio_match.sv
module mrd_ratio_match
  import mrd_pkg::*;
#(
  parameter int CNT_W = 10,
  parameter int TOL   = 8
) (
  input  logic [CNT_W-1:0] meas_i,
  output ratio_code_t      code_o
);
  logic [NUM_RATIO-1:0] hit;

  for (genvar i = 0; i < NUM_RATIO; i++) begin : g_win
    localparam int LO = nominal_ratio(i) - TOL;
    localparam int HI = nominal_ratio(i) + TOL;
    assign hit[i] = (int'(meas_i) >= LO) && (int'(meas_i) <= HI);
  end

  // windows never overlap, so at most one bit is set
  always_comb begin
    code_o = RATIO_NONE;
    for (int i = 0; i < NUM_RATIO; i++) begin
      if (hit[i]) code_o = ratio_code_t'(i);
    end
  end
endmodule

// File: rtl/mrd_lock_ctl.sv
module mrd_lock_ctl
  import mrd_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        active_i,
  input  logic        meas_valid_i,
  input  ratio_code_t code_i,
  output ratio_code_t ratio_o,
  output logic        lock_o,
  output logic        mute_o
);
  ratio_code_t cand_q;
  logic        agree;

  assign agree = (code_i != RATIO_NONE) && (code_i == cand_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_q  <= RATIO_NONE;
      ratio_o <= RATIO_NONE;
      lock_o  <= 1'b0;
      mute_o  <= 1'b1;
    end else if (!active_i) begin
      cand_q  <= RATIO_NONE;
      ratio_o <= RATIO_NONE;
      lock_o  <= 1'b0;
      mute_o  <= 1'b1;
    end else if (meas_valid_i) begin
      cand_q  <= code_i;
      ratio_o <= agree ? code_i : RATIO_NONE;
      lock_o  <= agree;
      mute_o  <= ~agree;
    end
  end
endmodule

// File: rtl/mclk_ratio_detect.sv
module mclk_ratio_detect
  import mrd_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int TOL         = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       lrclk_i,
  output logic [2:0] ratio_o,
  output logic       lock_o,
  output logic       mute_o
);
  logic             active;
  logic             lr_rise;
  logic [CNT_W-1:0] meas;
  logic             meas_valid;
  ratio_code_t      code;
  ratio_code_t      ratio_q;

  mrd_enable_ctl i_en (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .active_o(active)
  );

  mrd_lrclk_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lrclk_i(lrclk_i),
    .rise_o (lr_rise)
  );

  mrd_period_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .rise_i      (lr_rise),
    .meas_o      (meas),
    .meas_valid_o(meas_valid)
  );

  mrd_ratio_match #(.CNT_W(CNT_W), .TOL(TOL)) i_match (
    .meas_i(meas),
    .code_o(code)
  );

  mrd_lock_ctl i_lock (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .active_i    (active),
    .meas_valid_i(meas_valid),
    .code_i      (code),
    .ratio_o     (ratio_q),
    .lock_o      (lock_o),
    .mute_o      (mute_o)
  );

  assign ratio_o = ratio_q;
endmodule

// File: rtl/mrd_checker.sv
module mrd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       meas_valid,
  input logic [2:0] code,
  input logic [2:0] ratio_o,
  input logic       lock_o,
  input logic       mute_o
);
  assert_code_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> (ratio_o <= 3'd5));

  assert_none_when_unlocked_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |-> (ratio_o == 3'd7));

  assert_mute_on_miss_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_valid && code == 3'd7) |=> (mute_o && !lock_o));

  assert_lock_needs_meas_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> $past(meas_valid));

  assert_mute_vs_lock_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mute_o == !lock_o);

  assert_hold_between_meas_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!meas_valid && en_i) |=> $stable(ratio_o));

  assert_idle_when_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!lock_o && mute_o && ratio_o == 3'd7));
endmodule

bind mclk_ratio_detect mrd_checker i_mrd_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .meas_valid(meas_valid),
  .code      (code),
  .ratio_o   (ratio_o),
  .lock_o    (lock_o),
  .mute_o    (mute_o)
);

// File: tb/test_mclk_ratio_detect.sv
module test_mclk_ratio_detect;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b1;
  logic       lrclk_i = 1'b0;
  logic [2:0] ratio_o;
  logic       lock_o;
  logic       mute_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  mclk_ratio_detect i_mclk_ratio_detect (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .lrclk_i(lrclk_i),
    .ratio_o(ratio_o),
    .lock_o (lock_o),
    .mute_o (mute_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check_out(input string req, input logic e_lock, input logic e_mute,
                           input logic [2:0] e_ratio);
    n_checks++;
    if (lock_o !== e_lock || mute_o !== e_mute || ratio_o !== e_ratio) begin
      n_errors++;
      $display("FAIL %s: lock=%0b mute=%0b ratio=%0d expected lock=%0b mute=%0b ratio=%0d",
               req, lock_o, mute_o, ratio_o, e_lock, e_mute, e_ratio);
    end
  endtask

  // called on a falling edge; each rise lands exactly per clocks after the previous
  task automatic run_periods(input int per, input int count);
    for (int p = 0; p < count; p++) begin
      lrclk_i = 1'b1;
      repeat (per / 2) @(negedge clk_i);
      lrclk_i = 1'b0;
      repeat (per - per / 2) @(negedge clk_i);
    end
  endtask

  task automatic t_reset_no_edge;
    check_out("R10 reset state", 1'b0, 1'b1, 3'd7);
    run_periods(256, 4);
    check_out("R9 no start without enable edge", 1'b0, 1'b1, 3'd7);
  endtask

  task automatic t_two_period_lock;
    en_i = 1'b0;
    repeat (4) @(negedge clk_i);
    en_i = 1'b1;
    @(negedge clk_i);
    run_periods(384, 2);
    check_out("R4 one measured period not enough", 1'b0, 1'b1, 3'd7);
  endtask

  task automatic t_latency;
    lrclk_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check_out("R5 no update before third edge", 1'b0, 1'b1, 3'd7);
    @(negedge clk_i);
    check_out("R5 update on third edge, code 3 for 384", 1'b1, 1'b0, 3'd3);
    repeat (192 - 4) @(negedge clk_i);
    lrclk_i = 1'b0;
    repeat (192) @(negedge clk_i);
  endtask

  task automatic t_tolerance;
    run_periods(520, 3);
    check_out("R2 512+8 accepted", 1'b1, 1'b0, 3'd4);
    run_periods(504, 3);
    check_out("R2 512-8 accepted", 1'b1, 1'b0, 3'd4);
    run_periods(521, 2);
    check_out("R3 512+9 rejected", 1'b0, 1'b1, 3'd7);
    run_periods(120, 3);
    check_out("R1 R2 128-8 code 0", 1'b1, 1'b0, 3'd0);
    run_periods(776, 3);
    check_out("R1 R2 768+8 code 5", 1'b1, 1'b0, 3'd5);
  endtask

  task automatic t_gap_ratio;
    run_periods(320, 3);
    check_out("R3 unsupported 320", 1'b0, 1'b1, 3'd7);
    run_periods(192, 3);
    check_out("R1 192 code 1", 1'b1, 1'b0, 3'd1);
  endtask

  task automatic t_jitter;
    int pers[4] = '{197, 184, 200, 189};
    int highs[4] = '{60, 120, 33, 150};
    for (int j = 0; j < 4; j++) begin
      lrclk_i = 1'b1;
      repeat (highs[j]) @(negedge clk_i);
      lrclk_i = 1'b0;
      repeat (pers[j] - highs[j]) @(negedge clk_i);
      check_out("R6 jitter keeps lock", 1'b1, 1'b0, 3'd1);
    end
  endtask

  task automatic t_single_error;
    run_periods(256, 3);
    check_out("R1 256 code 2", 1'b1, 1'b0, 3'd2);
    run_periods(300, 1);
    run_periods(256, 1);
    check_out("R3 one bad period mutes", 1'b0, 1'b1, 3'd7);
    run_periods(256, 1);
    check_out("R4 first good period after error", 1'b0, 1'b1, 3'd7);
    run_periods(256, 1);
    check_out("R4 relock after two good", 1'b1, 1'b0, 3'd2);
  endtask

  task automatic t_ratio_change;
    run_periods(128, 2);
    check_out("R4 different ratio drops lock", 1'b0, 1'b1, 3'd7);
    run_periods(128, 1);
    check_out("R4 new ratio committed", 1'b1, 1'b0, 3'd0);
  endtask

  task automatic t_stopped_clock;
    repeat (1100) @(negedge clk_i);
    check_out("R7 stopped word clock mutes", 1'b0, 1'b1, 3'd7);
    run_periods(256, 3);
    check_out("R7 recovery after stall", 1'b1, 1'b0, 3'd2);
  endtask

  task automatic t_disable;
    en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check_out("R8 disable idles outputs", 1'b0, 1'b1, 3'd7);
    run_periods(256, 3);
    check_out("R8 idle while disabled", 1'b0, 1'b1, 3'd7);
    en_i = 1'b1;
    run_periods(256, 3);
    check_out("R9 restart after enable edge", 1'b1, 1'b0, 3'd2);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_no_edge();
    t_two_period_lock();
    t_latency();
    t_tolerance();
    t_gap_ratio();
    t_jitter();
    t_single_error();
    t_ratio_change();
    t_stopped_clock();
    t_disable();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule